// File: doc/BRIEF.md
# Modem Status and Interrupt Register

This block keeps the eight-bit status byte that a host processor reads from a four-level FSK modem, and it drives the modem's interrupt request. The modem core sends it events. A block-ready strobe marks that the shared data buffer may be serviced. A symbol count tells how full the interleave buffer is. Level flags report overflow of the data input buffer, a CRC error and valid signal. A strobe marks each sync symbol that is sent or received. The block also sees every command write, with its task code, and the current mode fields: transmit/receive, power save, interrupt pin enable and sync interrupt enable.

Every flag follows its own set and clear rules. A rising buffer-free or interleave-empty flag raises the interrupt bit. There is one exception: when the rise comes from a RESET task or from a change of the transmit/receive or power-save mode, the flag is set quietly and the interrupt bit is not raised. A host read of the status byte clears the interrupt bit and the sync-ready flag. An interrupt event in the same cycle as the read still wins, so no event is lost. The interrupt output is an active-high "pull low" request, which stands for an open-drain pin.

Top module: `modem_status_reg`

## Requirements
- R1: While reset is active, the status byte reads 0x60 (buffer-free and interleave-empty set, all other bits 0) and irqPullLow is 0. The bit layout is: bit 7 interrupt, bit 6 buffer-free, bit 5 interleave-empty, bit 4 input-buffer overflow, bit 3 sync-ready, bit 2 CRC error, bit 1 signal valid, bit 0 always 0.
- R2: Buffer-free clears one cycle after a command write whose task code is neither NULL (0x0) nor RESET (0x1). A NULL write changes nothing. A coreBlockReady strobe sets buffer-free, and if it was 0 it also sets the interrupt bit. If a clearing task write and coreBlockReady come in the same cycle, the task write wins.
- R3: A RESET task write, or a change of modeTx or modePsave, sets buffer-free and interleave-empty one cycle later without setting the interrupt bit.
- R4: Bit 4 follows dibOvfIn with one cycle of delay. Each 0-to-1 transition of dibOvfIn sets the interrupt bit, and a level that stays high does not set it again.
- R5: A syncStrobe sets sync-ready. It also sets the interrupt bit only when modeSyncIrqEn is 1.
- R6: In transmit (modeTx=1), interleave-empty sets together with the interrupt bit when ibCount is below 2, no clear is pending and the flag was 0.
- R7: A clearing task write in transmit clears interleave-empty on the first symTick after the write cycle, not before.
- R8: In receive (modeTx=0), interleave-empty reads 0 from the cycle after the mode is sampled, whatever ibCount is.
- R9: A status read clears the interrupt bit and sync-ready one cycle later. If an interrupt-setting event comes in the same cycle as the read, the interrupt bit stays 1.
- R10: irqPullLow is 1 exactly when modeIrqEn is 1 and the interrupt bit is 1.
- R11: Bits 2 and 1 follow crcErrIn and sigValidIn with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeTx | input | 1 | 1 = transmit, 0 = receive |
| modePsave | input | 1 | Power-save mode bit |
| modeIrqEn | input | 1 | Enables the interrupt pin |
| modeSyncIrqEn | input | 1 | Lets a sync symbol raise the interrupt |
| cmdWrite | input | 1 | Command register write strobe |
| cmdTask | input | 4 | Task code of the write (0x0 NULL, 0x1 RESET) |
| coreBlockReady | input | 1 | Core strobe: the data buffer is ready for the host |
| ibCount | input | CNT_W | Symbols left in the interleave buffer |
| symTick | input | 1 | One pulse per symbol period |
| dibOvfIn | input | 1 | Data input buffer overflow level |
| crcErrIn | input | 1 | CRC error level |
| sigValidIn | input | 1 | Signal valid level |
| syncStrobe | input | 1 | A sync symbol was sent or received |
| statusRd | input | 1 | Host read of the status byte |
| statusData | output | 8 | Status byte |
| irqPullLow | output | 1 | 1 = drive the interrupt line low |

## Verification
Every flag is a single register. A stimulus applied before a clock edge therefore shows in statusData from that edge onward, and irqPullLow follows the interrupt bit in the same cycle. The only exception is the interleave-empty clear, which waits for the first symTick after the task write. The driver applies each stimulus half a period before an edge and queues the expected byte for that edge. The monitor compares the byte shortly after the edge, while no input is changing. The coincident-read case and the quiet-set cases are driven in the very cycle that decides priority, and their effect is checked on the following edge.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int TASK_W = 4;
  localparam logic [TASK_W-1:0] TASK_NULL  = 4'h0;
  localparam logic [TASK_W-1:0] TASK_RESET = 4'h1;

  localparam int BIT_IRQ   = 7;
  localparam int BIT_BFREE = 6;
  localparam int BIT_IBE   = 5;
  localparam int BIT_DIB   = 4;
  localparam int BIT_SRDY  = 3;
  localparam int BIT_CRC   = 2;
  localparam int BIT_SVAL  = 1;

  typedef struct packed {
    logic silentSet;  // RESET task or mode change
    logic taskClr;    // task other than NULL/RESET
    logic dibRise;    // overflow 0->1
    logic syncSet;    // sync symbol seen
    logic syncIrq;    // sync symbol with interrupt enabled
    logic readClr;    // host read of status
  } msrStrobe_t;
endpackage

// File: rtl/msr_ctrl.sv
module msr_ctrl
  import msr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeTx,
  input  logic              modePsave,
  input  logic              modeSyncIrqEn,
  input  logic              cmdWrite,
  input  logic [TASK_W-1:0] cmdTask,
  input  logic              dibOvfIn,
  input  logic              syncStrobe,
  input  logic              statusRd,
  output msrStrobe_t        strobe
);
  logic prevTx, prevPsave, prevDib;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevTx    <= 1'b0;
      prevPsave <= 1'b0;
      prevDib   <= 1'b0;
    end else begin
      prevTx    <= modeTx;
      prevPsave <= modePsave;
      prevDib   <= dibOvfIn;
    end
  end

  logic isReset, isNull, modeChange;

  always_comb begin
    isReset    = (cmdTask == TASK_RESET);
    isNull     = (cmdTask == TASK_NULL);
    modeChange = (modeTx != prevTx) || (modePsave != prevPsave);
    strobe.silentSet = modeChange || (cmdWrite && isReset);
    strobe.taskClr   = cmdWrite && !isReset && !isNull;
    strobe.dibRise   = dibOvfIn && !prevDib;
    strobe.syncSet   = syncStrobe;
    strobe.syncIrq   = syncStrobe && modeSyncIrqEn;
    strobe.readClr   = statusRd;
  end
endmodule

// File: rtl/msr_datapath.sv
module msr_datapath
  import msr_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int IBE_LOW = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  msrStrobe_t       strobe,
  input  logic             modeTx,
  input  logic             coreBlockReady,
  input  logic [CNT_W-1:0] ibCount,
  input  logic             symTick,
  input  logic             dibOvfIn,
  input  logic             crcErrIn,
  input  logic             sigValidIn,
  output logic [7:0]       statusData
);
  localparam logic [CNT_W-1:0] LOW_MARK = CNT_W'(IBE_LOW);

  logic bfree, ibe, clrPending, irq, srdy, dibReg, crcReg, svalReg;
  logic bfreeNext, ibeNext, pendNext, bfreeRise, ibeRise, setIrq;

  always_comb begin
    bfreeNext = bfree;
    bfreeRise = 1'b0;
    if (strobe.silentSet)    bfreeNext = 1'b1;
    else if (strobe.taskClr) bfreeNext = 1'b0;
    else if (coreBlockReady) begin
      bfreeNext = 1'b1;
      bfreeRise = !bfree;
    end
  end

  always_comb begin
    ibeNext  = ibe;
    ibeRise  = 1'b0;
    pendNext = clrPending;
    if (clrPending && symTick) pendNext = 1'b0;
    if (strobe.taskClr && modeTx && !strobe.silentSet) pendNext = 1'b1;
    if (!modeTx) begin
      ibeNext  = 1'b0;
      pendNext = 1'b0;
    end else if (strobe.silentSet) begin
      ibeNext  = 1'b1;
      pendNext = 1'b0;
    end else if (clrPending && symTick) begin
      ibeNext = 1'b0;
    end else if (!clrPending && (ibCount < LOW_MARK) && !ibe) begin
      ibeNext = 1'b1;
      ibeRise = 1'b1;
    end
  end

  assign setIrq = bfreeRise || ibeRise || strobe.dibRise || strobe.syncIrq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bfree      <= 1'b1;
      ibe        <= 1'b1;
      clrPending <= 1'b0;
      irq        <= 1'b0;
      srdy       <= 1'b0;
      dibReg     <= 1'b0;
      crcReg     <= 1'b0;
      svalReg    <= 1'b0;
    end else begin
      bfree      <= bfreeNext;
      ibe        <= ibeNext;
      clrPending <= pendNext;
      if (setIrq)              irq <= 1'b1;
      else if (strobe.readClr) irq <= 1'b0;
      if (strobe.syncSet)      srdy <= 1'b1;
      else if (strobe.readClr) srdy <= 1'b0;
      dibReg     <= dibOvfIn;
      crcReg     <= crcErrIn;
      svalReg    <= sigValidIn;
    end
  end

  always_comb begin
    statusData = '0;
    statusData[BIT_IRQ]   = irq;
    statusData[BIT_BFREE] = bfree;
    statusData[BIT_IBE]   = ibe;
    statusData[BIT_DIB]   = dibReg;
    statusData[BIT_SRDY]  = srdy;
    statusData[BIT_CRC]   = crcReg;
    statusData[BIT_SVAL]  = svalReg;
  end

  p_task_clears_bfree_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.taskClr && !strobe.silentSet) |=> !bfree);
  p_quiet_set_no_irq_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.silentSet && !irq && !strobe.dibRise && !strobe.syncIrq) |=> (!irq && bfree));
  p_dib_rise_irq_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dibRise |=> irq);
  p_rx_ibe_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    !modeTx |=> !ibe);
  p_read_clears_irq_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.readClr && !setIrq) |=> !irq);
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
  import msr_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int IBE_LOW = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeTx,
  input  logic              modePsave,
  input  logic              modeIrqEn,
  input  logic              modeSyncIrqEn,
  input  logic              cmdWrite,
  input  logic [TASK_W-1:0] cmdTask,
  input  logic              coreBlockReady,
  input  logic [CNT_W-1:0]  ibCount,
  input  logic              symTick,
  input  logic              dibOvfIn,
  input  logic              crcErrIn,
  input  logic              sigValidIn,
  input  logic              syncStrobe,
  input  logic              statusRd,
  output logic [7:0]        statusData,
  output logic              irqPullLow
);
  msrStrobe_t strobe;

  msr_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .modeTx(modeTx), .modePsave(modePsave),
    .modeSyncIrqEn(modeSyncIrqEn), .cmdWrite(cmdWrite), .cmdTask(cmdTask),
    .dibOvfIn(dibOvfIn), .syncStrobe(syncStrobe), .statusRd(statusRd),
    .strobe(strobe)
  );

  msr_datapath #(.CNT_W(CNT_W), .IBE_LOW(IBE_LOW)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .modeTx(modeTx),
    .coreBlockReady(coreBlockReady), .ibCount(ibCount), .symTick(symTick),
    .dibOvfIn(dibOvfIn), .crcErrIn(crcErrIn), .sigValidIn(sigValidIn),
    .statusData(statusData)
  );

  assign irqPullLow = modeIrqEn && statusData[BIT_IRQ];
endmodule

// File: tb/modem_status_reg_tb.sv
module modem_status_reg_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeTx = 0, modePsave = 0, modeIrqEn = 1, modeSyncIrqEn = 0;
  logic cmdWrite = 0;
  logic [3:0] cmdTask = 4'h0;
  logic coreBlockReady = 0;
  logic [3:0] ibCount = 4'd8;
  logic symTick = 0, dibOvfIn = 0, crcErrIn = 0, sigValidIn = 0;
  logic syncStrobe = 0, statusRd = 0;
  logic [7:0] statusData;
  logic irqPullLow;

  always #(CLK_PERIOD/2) clk = ~clk;

  modem_status_reg dut_i (
    .clk(clk), .rstN(rstN), .modeTx(modeTx), .modePsave(modePsave),
    .modeIrqEn(modeIrqEn), .modeSyncIrqEn(modeSyncIrqEn),
    .cmdWrite(cmdWrite), .cmdTask(cmdTask), .coreBlockReady(coreBlockReady),
    .ibCount(ibCount), .symTick(symTick), .dibOvfIn(dibOvfIn),
    .crcErrIn(crcErrIn), .sigValidIn(sigValidIn), .syncStrobe(syncStrobe),
    .statusRd(statusRd), .statusData(statusData), .irqPullLow(irqPullLow)
  );

  typedef struct {
    logic [7:0] stat;
    logic       pin;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  // driver: one clock edge, then queue what that edge must produce
  task automatic edgeExpect(input logic [7:0] st, input logic pin, input string tag);
    @(posedge clk);
    #1;
    expQ.push_back('{stat: st, pin: pin, tag: tag});
    @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        checks++;
        if (statusData !== e.stat || irqPullLow !== e.pin) begin
          fails++;
          $display("FAIL %s: status=%02h pin=%b expected status=%02h pin=%b",
                   e.tag, statusData, irqPullLow, e.stat, e.pin);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    edgeExpect(8'h60, 1'b0, "R1 reset value");
    rstN = 1'b1;
    edgeExpect(8'h40, 1'b0, "R8 receive forces interleave-empty low");

    modeTx = 1;
    edgeExpect(8'h60, 1'b0, "R3 mode change quiet set");

    cmdWrite = 1; cmdTask = 4'h2;
    edgeExpect(8'h20, 1'b0, "R2 task clears buffer-free");
    cmdWrite = 0;
    edgeExpect(8'h20, 1'b0, "R7 interleave-empty held until tick");
    symTick = 1;
    edgeExpect(8'h00, 1'b0, "R7 cleared on symbol tick");
    symTick = 0;

    coreBlockReady = 1;
    edgeExpect(8'hC0, 1'b1, "R2 block ready sets flag and interrupt");
    coreBlockReady = 0;
    statusRd = 1;
    edgeExpect(8'h40, 1'b0, "R9 read clears interrupt");
    statusRd = 0;

    ibCount = 4'd1;
    edgeExpect(8'hE0, 1'b1, "R6 low count sets interleave-empty");
    modeIrqEn = 0;
    edgeExpect(8'hE0, 1'b0, "R10 pin released when disabled");
    modeIrqEn = 1;
    statusRd = 1;
    edgeExpect(8'h60, 1'b0, "R9 read clears interrupt again");
    statusRd = 0;

    cmdWrite = 1; cmdTask = 4'h3;
    edgeExpect(8'h20, 1'b0, "R2 second task clears buffer-free");
    cmdWrite = 0; ibCount = 4'd8;
    cmdWrite = 1; cmdTask = 4'h1;
    edgeExpect(8'h60, 1'b0, "R3 RESET task quiet set");
    cmdTask = 4'h0;
    edgeExpect(8'h60, 1'b0, "R2 NULL task has no effect");
    cmdWrite = 0;

    dibOvfIn = 1;
    edgeExpect(8'hF0, 1'b1, "R4 overflow rise sets interrupt");
    statusRd = 1;
    edgeExpect(8'h70, 1'b0, "R9 read clears overflow interrupt");
    statusRd = 0;
    edgeExpect(8'h70, 1'b0, "R4 steady overflow no new interrupt");
    dibOvfIn = 0;
    edgeExpect(8'h60, 1'b0, "R4 overflow bit follows input");

    syncStrobe = 1;
    edgeExpect(8'h68, 1'b0, "R5 sync without enable");
    syncStrobe = 0;
    statusRd = 1;
    edgeExpect(8'h60, 1'b0, "R9 read clears sync-ready");
    statusRd = 0;
    modeSyncIrqEn = 1; syncStrobe = 1;
    edgeExpect(8'hE8, 1'b1, "R5 sync with enable raises interrupt");
    syncStrobe = 0;

    statusRd = 1; dibOvfIn = 1;
    edgeExpect(8'hF0, 1'b1, "R9 set event beats coincident read");
    edgeExpect(8'h70, 1'b0, "R9 following read clears");
    statusRd = 0; dibOvfIn = 0;
    edgeExpect(8'h60, 1'b0, "R4 overflow cleared");

    crcErrIn = 1; sigValidIn = 1;
    edgeExpect(8'h66, 1'b0, "R11 crc and valid mirrored");
    crcErrIn = 0; sigValidIn = 0;
    edgeExpect(8'h60, 1'b0, "R11 crc and valid cleared");

    cmdWrite = 1; cmdTask = 4'h2;
    edgeExpect(8'h20, 1'b0, "R2 task before power-save change");
    cmdWrite = 0; modePsave = 1;
    edgeExpect(8'h60, 1'b0, "R3 power-save change quiet set");

    modeTx = 0;
    edgeExpect(8'h40, 1'b0, "R8 switch to receive");
    ibCount = 4'd0;
    edgeExpect(8'h40, 1'b0, "R8 low count ignored in receive");
    cmdWrite = 1; cmdTask = 4'h4;
    edgeExpect(8'h00, 1'b0, "R2 receive task clears buffer-free");
    cmdWrite = 0; coreBlockReady = 1;
    edgeExpect(8'hC0, 1'b1, "R2 receive completion sets interrupt");
    coreBlockReady = 0; statusRd = 1;
    edgeExpect(8'h40, 1'b0, "R9 final read");
    statusRd = 0;

    @(posedge clk);
    #5;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule